// File: doc/BRIEF.md
# Pulse-Disciplined Digital Frequency Synthesizer

The block takes a free-running local clock, nominally around 50 MHz, and a once-per-second reference pulse from an outside timing source. It counts local clock cycles between consecutive reference edges and sums those counts over a window of whole seconds. At the end of each window it computes the signed difference from the expected count and uses that difference to trim the tuning word of a phase-accumulator synthesizer. The oscillator itself is never touched. All of the correction goes into the digital phase increment, so the synthesized square wave follows true time even when the local clock runs fast or slow.

Software sets the nominal count per second, the window length in seconds, a right-shift loop gain and the allowed tuning-word range. Long windows, up to thousands of seconds, average the one-cycle quantisation of a single gate down to a very small fraction. The most recent one-second count is also shown as a plain frequency-counter reading. If the reference stops, the block enters holdover and keeps the last tuning word.

Top module: `pps_dds_discipline`

## Requirements
- R1: After reset, tw_out, sec_count, err_out, err_valid, holdover and dds_out are all zero.
- R2: While en is low, tw_out takes the value of tw_init one clock later, and the measurement state is cleared.
- R3: The pulse input passes through two synchronizing flops. Only its rising edge counts, so a pulse held high for many cycles counts once. On every edge after the first, sec_count is loaded with the number of local clocks since the previous edge.
- R4: The first edge after en rises, and the first edge after holdover, only opens a window and produces no err_valid.
- R5: Let N be win_secs, with 0 treated as 1. Once N further edges have arrived, err_valid pulses for one cycle. At the same time err_out is set to the signed value (sum of the N one-second counts) minus N times nominal_cnt.
- R6: On the clock after err_valid, tw_out becomes tw_out minus (err_out arithmetically shifted right by gain_shift). At no other time while en is high does tw_out change.
- R7: Each updated tuning word is clamped to the range tw_min to tw_max, both limits included and unsigned.
- R8: Holdover starts when nominal_cnt + nominal_cnt/2 clocks pass with no edge after an armed edge. holdover then goes high, the partial window is dropped, tw_out is kept and err_valid stays low. The next edge clears holdover.
- R9: A 32-bit phase accumulator adds tw_out on every clock, and dds_out is its top bit. Over 64 clocks, a tuning word of 2^(32-k) gives 2^(6-k) rising edges of dds_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oscillator clock |
| rst_n | input | 1 | Active-low reset |
| en | input | 1 | Enable discipline; low loads tw_init |
| pps_in | input | 1 | Asynchronous once-per-second reference |
| nominal_cnt | input | 32 | Expected local clocks per second |
| win_secs | input | 12 | Window length in seconds |
| gain_shift | input | 6 | Right shift applied to the error |
| tw_init | input | 32 | Starting tuning word |
| tw_min | input | 32 | Lower tuning-word limit |
| tw_max | input | 32 | Upper tuning-word limit |
| tw_out | output | 32 | Current tuning word |
| dds_out | output | 1 | Synthesized square wave |
| holdover | output | 1 | Reference lost, word frozen |
| sec_count | output | 32 | Last one-second gated count |
| err_out | output | 45 | Signed window error |
| err_valid | output | 1 | One-cycle strobe for err_out |

## Verification
The bench uses a scaled-down second of about a thousand clocks. It drives reference trains whose spacing is above, equal to or below the nominal count. This separates the sign of the correction, the zero-error case and the window sum over two seconds. Narrow and very wide pulses show that only the edge is counted. Trains that push the word past either limit show the clamp. A long gap followed by fresh pulses covers holdover entry and re-arming. Fixed power-of-two tuning words set the expected count of output edges.

// File: rtl/pps_dds_pkg.sv
package pps_dds_pkg;
    localparam int PHASE_W = 32;
    localparam int CNT_W   = 32;
    localparam int WIN_W   = 12;
    localparam int SHIFT_W = 6;
    localparam int ACC_W   = CNT_W + WIN_W;
    localparam int ERR_W   = ACC_W + 1;
    localparam int SUM_W   = ERR_W + 1;
endpackage

// File: rtl/pps_edge_sync.sv
module pps_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_i,
    output logic rise_o
);
    typedef struct packed {
        logic [2:0] sh;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.sh = {st_q.sh[1:0], pulse_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.sh[1] & ~st_q.sh[2];
endmodule

// File: rtl/pps_gate_counter.sv
module pps_gate_counter
    import pps_dds_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    rise_i,
    input  logic [CNT_W-1:0]        nominal_i,
    input  logic [WIN_W-1:0]        win_i,
    output logic [CNT_W-1:0]        sec_o,
    output logic signed [ERR_W-1:0] err_o,
    output logic                    vld_o,
    output logic                    hold_o
);
    typedef struct packed {
        logic                    armed;
        logic                    hold;
        logic [CNT_W-1:0]        cyc;
        logic [WIN_W-1:0]        idx;
        logic [ACC_W-1:0]        acc;
        logic [CNT_W-1:0]        sec;
        logic signed [ERR_W-1:0] err;
        logic                    vld;
    } gate_t;

    gate_t st_d, st_q;

    logic [CNT_W:0]   limit;
    logic [WIN_W-1:0] win_eff;
    logic [WIN_W:0]   idx_next;
    logic [ACC_W-1:0] target;
    logic [ACC_W-1:0] sum;

    always_comb begin
        limit    = {1'b0, nominal_i} + {2'b0, nominal_i[CNT_W-1:1]};
        win_eff  = (win_i == '0) ? WIN_W'(1) : win_i;
        idx_next = {1'b0, st_q.idx} + (WIN_W+1)'(1);
        target   = ACC_W'(win_eff) * ACC_W'(nominal_i);
        sum      = st_q.acc + ACC_W'(st_q.cyc);

        st_d     = st_q;
        st_d.vld = 1'b0;
        if (!en) begin
            st_d.armed = 1'b0;
            st_d.hold  = 1'b0;
            st_d.cyc   = '0;
            st_d.idx   = '0;
            st_d.acc   = '0;
        end else if (rise_i) begin
            if (st_q.armed) begin
                st_d.sec = st_q.cyc;
                if (idx_next >= {1'b0, win_eff}) begin
                    st_d.err = $signed({1'b0, sum}) - $signed({1'b0, target});
                    st_d.vld = 1'b1;
                    st_d.acc = '0;
                    st_d.idx = '0;
                end else begin
                    st_d.acc = sum;
                    st_d.idx = idx_next[WIN_W-1:0];
                end
            end else begin
                st_d.armed = 1'b1;
                st_d.hold  = 1'b0;
                st_d.acc   = '0;
                st_d.idx   = '0;
            end
            st_d.cyc = CNT_W'(1);
        end else if (st_q.armed) begin
            if ({1'b0, st_q.cyc} >= limit) begin
                st_d.armed = 1'b0;
                st_d.hold  = 1'b1;
                st_d.cyc   = '0;
                st_d.acc   = '0;
                st_d.idx   = '0;
            end else begin
                st_d.cyc = st_q.cyc + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sec_o  = st_q.sec;
    assign err_o  = st_q.err;
    assign vld_o  = st_q.vld;
    assign hold_o = st_q.hold;
endmodule

// File: rtl/pps_tune_ctrl.sv
module pps_tune_ctrl
    import pps_dds_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    vld_i,
    input  logic signed [ERR_W-1:0] err_i,
    input  logic [SHIFT_W-1:0]      shift_i,
    input  logic [PHASE_W-1:0]      init_i,
    input  logic [PHASE_W-1:0]      min_i,
    input  logic [PHASE_W-1:0]      max_i,
    output logic [PHASE_W-1:0]      tw_o
);
    localparam int PAD = SUM_W - PHASE_W;

    typedef struct packed {
        logic [PHASE_W-1:0] tw;
    } tune_t;

    tune_t st_d, st_q;

    logic signed [ERR_W-1:0] err_sh;
    logic signed [SUM_W-1:0] cand, lo, hi;

    always_comb begin
        err_sh = err_i >>> shift_i;
        cand   = $signed({{PAD{1'b0}}, st_q.tw}) - SUM_W'(err_sh);
        lo     = $signed({{PAD{1'b0}}, min_i});
        hi     = $signed({{PAD{1'b0}}, max_i});

        st_d = st_q;
        if (!en) begin
            st_d.tw = init_i;
        end else if (vld_i) begin
            if (cand < lo)      st_d.tw = min_i;
            else if (cand > hi) st_d.tw = max_i;
            else                st_d.tw = cand[PHASE_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tw_o = st_q.tw;
endmodule

// File: rtl/pps_phase_acc.sv
module pps_phase_acc
    import pps_dds_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] tw_i,
    output logic               msb_o
);
    typedef struct packed {
        logic [PHASE_W-1:0] ph;
    } acc_t;

    acc_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.ph = st_q.ph + tw_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign msb_o = st_q.ph[PHASE_W-1];
endmodule

// File: rtl/pps_dds_discipline.sv
module pps_dds_discipline
    import pps_dds_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    pps_in,
    input  logic [CNT_W-1:0]        nominal_cnt,
    input  logic [WIN_W-1:0]        win_secs,
    input  logic [SHIFT_W-1:0]      gain_shift,
    input  logic [PHASE_W-1:0]      tw_init,
    input  logic [PHASE_W-1:0]      tw_min,
    input  logic [PHASE_W-1:0]      tw_max,
    output logic [PHASE_W-1:0]      tw_out,
    output logic                    dds_out,
    output logic                    holdover,
    output logic [CNT_W-1:0]        sec_count,
    output logic signed [ERR_W-1:0] err_out,
    output logic                    err_valid
);
    logic rise;

    pps_edge_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pulse_i (pps_in),
        .rise_o  (rise)
    );

    pps_gate_counter u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .rise_i    (rise),
        .nominal_i (nominal_cnt),
        .win_i     (win_secs),
        .sec_o     (sec_count),
        .err_o     (err_out),
        .vld_o     (err_valid),
        .hold_o    (holdover)
    );

    pps_tune_ctrl u_tune (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .vld_i   (err_valid),
        .err_i   (err_out),
        .shift_i (gain_shift),
        .init_i  (tw_init),
        .min_i   (tw_min),
        .max_i   (tw_max),
        .tw_o    (tw_out)
    );

    pps_phase_acc u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .tw_i  (tw_out),
        .msb_o (dds_out)
    );
endmodule

// File: rtl/pps_dds_checker.sv
module pps_dds_checker
    import pps_dds_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               en,
    input logic [PHASE_W-1:0] tw_init,
    input logic [PHASE_W-1:0] tw_min,
    input logic [PHASE_W-1:0] tw_max,
    input logic [PHASE_W-1:0] tw_out,
    input logic               holdover,
    input logic               err_valid
);
    // R2
    init_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (tw_out == $past(tw_init)));

    // R5
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |=> !err_valid);

    // R6
    tw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !err_valid) |=> $stable(tw_out));

    // R7
    tw_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && err_valid) |=> (!en || (tw_out >= tw_min && tw_out <= tw_max)));

    // R8
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        holdover |-> !err_valid);
endmodule

bind pps_dds_discipline pps_dds_checker u_pps_dds_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .tw_init   (tw_init),
    .tw_min    (tw_min),
    .tw_max    (tw_max),
    .tw_out    (tw_out),
    .holdover  (holdover),
    .err_valid (err_valid)
);

// File: tb/test_pps_dds_discipline.sv
`timescale 1ns/1ps
module test_pps_dds_discipline;
    import pps_dds_pkg::*;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    en = 1'b0;
    logic                    pps_in = 1'b0;
    logic [CNT_W-1:0]        nominal_cnt = 32'd1000;
    logic [WIN_W-1:0]        win_secs = 12'd1;
    logic [SHIFT_W-1:0]      gain_shift = '0;
    logic [PHASE_W-1:0]      tw_init = '0;
    logic [PHASE_W-1:0]      tw_min = '0;
    logic [PHASE_W-1:0]      tw_max = '1;
    logic [PHASE_W-1:0]      tw_out;
    logic                    dds_out;
    logic                    holdover;
    logic [CNT_W-1:0]        sec_count;
    logic signed [ERR_W-1:0] err_out;
    logic                    err_valid;

    int     n_cmp = 0;
    int     n_bad = 0;
    int     n_vld = 0;
    longint last_err = 0;

    localparam longint BASE = 64'd1000000;

    always #2.5 clk = ~clk;

    pps_dds_discipline i_pps_dds_discipline (
        .clk(clk), .rst_n(rst_n), .en(en), .pps_in(pps_in),
        .nominal_cnt(nominal_cnt), .win_secs(win_secs), .gain_shift(gain_shift),
        .tw_init(tw_init), .tw_min(tw_min), .tw_max(tw_max),
        .tw_out(tw_out), .dds_out(dds_out), .holdover(holdover),
        .sec_count(sec_count), .err_out(err_out), .err_valid(err_valid)
    );

    always @(negedge clk) begin
        if (err_valid) begin
            n_vld    = n_vld + 1;
            last_err = longint'(err_out);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pps_train(input int period, input int count, input int width);
        for (int i = 0; i < count; i++) begin
            pps_in = 1'b1;
            tick(width);
            pps_in = 1'b0;
            tick(period - width);
        end
    endtask

    task automatic setup(input int win, input int sh, input longint lo, input longint hi);
        en         = 1'b0;
        pps_in     = 1'b0;
        win_secs   = WIN_W'(win);
        gain_shift = SHIFT_W'(sh);
        tw_init    = PHASE_W'(BASE);
        tw_min     = PHASE_W'(lo);
        tw_max     = PHASE_W'(hi);
        tick(4);
        en = 1'b1;
        tick(2);
    endtask

    task automatic test_reset();
        check("R1 tw_out", longint'(tw_out), 0);
        check("R1 sec_count", longint'(sec_count), 0);
        check("R1 err_valid", longint'(err_valid), 0);
        check("R1 holdover", longint'(holdover), 0);
        check("R1 dds_out", longint'(dds_out), 0);
    endtask

    task automatic test_init_load();
        en      = 1'b0;
        tw_init = 32'h1234_5678;
        tick(2);
        check("R2 tw follows init", longint'(tw_out), 64'h1234_5678);
    endtask

    task automatic test_window_two();
        int v0;
        setup(2, 1, 0, 64'hFFFF_FFFF);
        v0 = n_vld;
        pps_train(1002, 1, 3);
        check("R4 first edge no sample", n_vld - v0, 0);
        pps_train(1002, 2, 3);
        check("R5 one sample per window", n_vld - v0, 1);
        check("R5 window error", last_err, 4);
        check("R3 sec_count", longint'(sec_count), 1002);
        check("R6 tw after shifted error", longint'(tw_out), BASE - 2);
    endtask

    task automatic test_slow_clock();
        int v0;
        setup(1, 0, 0, 64'hFFFF_FFFF);
        v0 = n_vld;
        pps_train(995, 3, 3);
        check("R5 samples", n_vld - v0, 2);
        check("R5 negative error", last_err, -5);
        check("R6 tw raised", longint'(tw_out), BASE + 10);
    endtask

    task automatic test_clamp();
        setup(1, 0, BASE - 4, BASE + 3);
        pps_train(990, 2, 3);
        check("R7 clamp at max", longint'(tw_out), BASE + 3);
        setup(1, 0, BASE - 4, BASE + 3);
        pps_train(1020, 2, 3);
        check("R7 clamp at min", longint'(tw_out), BASE - 4);
    endtask

    task automatic test_holdover();
        int v0;
        setup(1, 0, 0, 64'hFFFF_FFFF);
        pps_train(998, 2, 3);
        check("R6 tw before loss", longint'(tw_out), BASE + 2);
        v0 = n_vld;
        tick(1600);
        check("R8 holdover set", longint'(holdover), 1);
        check("R8 tw kept", longint'(tw_out), BASE + 2);
        check("R8 no sample", n_vld - v0, 0);
        pps_train(998, 1, 3);
        check("R8 holdover cleared", longint'(holdover), 0);
        check("R4 rearm no sample", n_vld - v0, 0);
        pps_train(998, 1, 3);
        check("R8 sampling resumes", n_vld - v0, 1);
        check("R6 tw after resume", longint'(tw_out), BASE + 4);
    endtask

    task automatic test_wide_pulse();
        int v0;
        setup(1, 0, 0, 64'hFFFF_FFFF);
        v0 = n_vld;
        pps_train(1000, 3, 50);
        check("R3 wide pulse counts once", n_vld - v0, 2);
        check("R3 sec_count wide", longint'(sec_count), 1000);
        check("R5 zero error", last_err, 0);
        check("R6 tw unchanged at zero error", longint'(tw_out), BASE);
    endtask

    task automatic count_rises(input logic [PHASE_W-1:0] tw, input int exp);
        int   rises;
        logic prev;
        en      = 1'b0;
        tw_init = tw;
        tick(3);
        rises = 0;
        prev  = dds_out;
        for (int i = 0; i < 64; i++) begin
            tick(1);
            if (dds_out && !prev) rises++;
            prev = dds_out;
        end
        check("R9 dds rising edges", rises, exp);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        test_reset();
        test_init_load();
        test_window_two();
        test_slow_clock();
        test_clamp();
        test_holdover();
        test_wide_pulse();
        count_rises(32'h8000_0000, 32);
        count_rises(32'h4000_0000, 16);
        count_rises(32'h2000_0000, 8);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule